// File: doc/BRIEF.md
# Narrow-to-Wide Registered Bus Exchanger

This block joins a fast narrow port (A, 12 bits) to a slower wide side made of two 12-bit ports (1B and 2B, 24 bits together). Going from A to B, two words that arrive one after the other on A are collected and shown together as one wide word. The first word takes a two-register path to 1B. The second word takes a one-register path to 2B. Because of this, the earlier word waits in its first stage while the later word is being captured, and both reach the wide side on the same clock edge.

Going from B to A, the values on 1B and 2B are captured into two registers. A select input then picks which of the two captured values drives A. Every register loads on the rising clock edge, and only while its active-low load enable is low. Each port has an active-low output enable. Three-state outputs are modelled as a data value plus a drive flag. A synchronous active-high reset clears every register.

Top module: `narrow_wide_xchg`

## Requirements
- R1: One rising edge with `rst` high sets `b1_out`, `b2_out` and `a_out` to zero, whatever `sel` is.
- R2: The first-stage register samples `a_in` on a rising edge only while `ld_a1_n` is 0. Otherwise it keeps its value, which shows up on `b1_out` at the next second-stage load.
- R3: On a rising edge with `ld_a2_n` at 0, `b1_out` takes the value the first stage held before that edge, and `b2_out` takes `a_in`.
- R4: While `ld_a2_n` is 1, `b1_out` and `b2_out` keep their values, even when `a_in` changes.
- R5: Take a word W0 loaded with `ld_a1_n` at 0, followed on the next edge by a word W1 loaded with `ld_a2_n` at 0. After that second edge, `b1_out` is W0 and `b2_out` is W1.
- R6: When `ld_a1_n` and `ld_a2_n` are both 0 on the same edge, `b1_out` gets the old first-stage value and the first stage gets the new `a_in`.
- R7: On a rising edge with `ld_b_n` at 0, both B-side inputs are captured. While `ld_b_n` is 1, the captured values hold even when `b1_in` and `b2_in` change.
- R8: `a_out` shows the captured 1B value when `sel` is 0 and the captured 2B value when `sel` is 1. It follows `sel` with no clock edge needed.
- R9: Each drive flag (`a_drv`, `b1_drv`, `b2_drv`) is 1 exactly when its output enable (`oe_a_n`, `oe_b1_n`, `oe_b2_n`) is 0. The output enables never change the register contents.
- R10: Reset takes priority over every load enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 12 | Narrow-side input data |
| ld_a1_n | input | 1 | Load enable for the first 1B stage, active low |
| ld_a2_n | input | 1 | Load enable for the second 1B stage and the 2B register, active low |
| ld_b_n | input | 1 | Load enable for the 1B and 2B capture registers, active low |
| sel | input | 1 | Picks the value for A: 0 for captured 1B, 1 for captured 2B |
| b1_in | input | 12 | 1B input data |
| b2_in | input | 12 | 2B input data |
| oe_a_n | input | 1 | Output enable for port A, active low |
| oe_b1_n | input | 1 | Output enable for port 1B, active low |
| oe_b2_n | input | 1 | Output enable for port 2B, active low |
| a_out | output | 12 | Narrow-side output data |
| a_drv | output | 1 | Drive flag for port A |
| b1_out | output | 12 | 1B output data |
| b1_drv | output | 1 | Drive flag for port 1B |
| b2_out | output | 12 | 2B output data |
| b2_drv | output | 1 | Drive flag for port 2B |

## Verification
The bench runs hundreds of word pairs through the assembly sequence.

- **Pair order:** It checks that the earlier word lands on 1B and the later word on 2B. A design with the two path depths swapped would show the words in reverse order. A design that fed 1B from the live input would show the second word twice.
- **Both A-side enables low together:** This case catches a design that passes the new word straight through to 1B instead of the old first-stage value.
- **Held B-side inputs:** The bench changes the B-side inputs and `a_in` while their loads are off. A design that muxed live inputs onto A, or loaded without its enable, would follow those changes.
- **Output enables and reset:** It sweeps every output-enable combination to catch inverted drive flags. It also resets with every load enabled, to catch a reset that loses to a load.

// File: rtl/narrow_wide_xchg.sv
module narrow_wide_xchg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic         ld_a1_n,
  input  logic         ld_a2_n,
  input  logic         ld_b_n,
  input  logic         sel,
  input  logic [W-1:0] b1_in,
  input  logic [W-1:0] b2_in,
  input  logic         oe_a_n,
  input  logic         oe_b1_n,
  input  logic         oe_b2_n,
  output logic [W-1:0] a_out,
  output logic         a_drv,
  output logic [W-1:0] b1_out,
  output logic         b1_drv,
  output logic [W-1:0] b2_out,
  output logic         b2_drv
);

  logic [W-1:0] hold_1b;
  logic [W-1:0] out_1b;
  logic [W-1:0] out_2b;
  logic [W-1:0] cap_1b;
  logic [W-1:0] cap_2b;

  always_ff @(posedge clk) begin
    if (rst) hold_1b <= '0;
    else if (!ld_a1_n) hold_1b <= a_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_1b <= '0;
      out_2b <= '0;
    end else if (!ld_a2_n) begin
      out_1b <= hold_1b;
      out_2b <= a_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_1b <= '0;
      cap_2b <= '0;
    end else if (!ld_b_n) begin
      cap_1b <= b1_in;
      cap_2b <= b2_in;
    end
  end

  assign a_out  = sel ? cap_2b : cap_1b;
  assign b1_out = out_1b;
  assign b2_out = out_2b;
  assign a_drv  = ~oe_a_n;
  assign b1_drv = ~oe_b1_n;
  assign b2_drv = ~oe_b2_n;

endmodule

module narrow_wide_xchg_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic         ld_a2_n,
  input logic         ld_b_n,
  input logic         sel,
  input logic [W-1:0] b1_in,
  input logic [W-1:0] b2_in,
  input logic [W-1:0] stage1,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b1_out,
  input logic [W-1:0] b2_out
);

  assert_b2_load_R3: assert property (@(posedge clk) disable iff (rst)
    !ld_a2_n |=> b2_out == $past(a_in));

  assert_b1_old_stage_R6: assert property (@(posedge clk) disable iff (rst)
    !ld_a2_n |=> b1_out == $past(stage1));

  assert_b_hold_R4: assert property (@(posedge clk) disable iff (rst)
    ld_a2_n |=> $stable(b1_out) && $stable(b2_out));

  assert_capture_R7: assert property (@(posedge clk) disable iff (rst)
    !ld_b_n |=> (sel ? (a_out == $past(b2_in)) : (a_out == $past(b1_in))));

  assert_capture_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (ld_b_n && sel == $past(sel)) |=> (sel != $past(sel)) || $stable(a_out));

endmodule

bind narrow_wide_xchg narrow_wide_xchg_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .a_in(a_in), .ld_a2_n(ld_a2_n), .ld_b_n(ld_b_n),
  .sel(sel), .b1_in(b1_in), .b2_in(b2_in), .stage1(hold_1b),
  .a_out(a_out), .b1_out(b1_out), .b2_out(b2_out)
);

// File: tb/test_narrow_wide_xchg.sv
module test_narrow_wide_xchg;
  localparam int W = 12;

  logic         clk = 0;
  logic         rst;
  logic [W-1:0] a_in, b1_in, b2_in;
  logic         ld_a1_n, ld_a2_n, ld_b_n, sel;
  logic         oe_a_n, oe_b1_n, oe_b2_n;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic         a_drv, b1_drv, b2_drv;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  narrow_wide_xchg #(.W(W)) i_narrow_wide_xchg (
    .clk(clk), .rst(rst), .a_in(a_in), .ld_a1_n(ld_a1_n), .ld_a2_n(ld_a2_n),
    .ld_b_n(ld_b_n), .sel(sel), .b1_in(b1_in), .b2_in(b2_in),
    .oe_a_n(oe_a_n), .oe_b1_n(oe_b1_n), .oe_b2_n(oe_b2_n),
    .a_out(a_out), .a_drv(a_drv), .b1_out(b1_out), .b1_drv(b1_drv),
    .b2_out(b2_out), .b2_drv(b2_drv)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] wgen(input int i, input int k);
    return W'((i * 37 + k * 1291 + 5) ^ (i << 4));
  endfunction

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] w0, w1, w2, p, q;
    rst = 1; a_in = '0; b1_in = '0; b2_in = '0;
    ld_a1_n = 1; ld_a2_n = 1; ld_b_n = 1; sel = 0;
    oe_a_n = 1; oe_b1_n = 1; oe_b2_n = 1;
    step(); step();
    // R1 reset state
    chk("R1 b1", b1_out, '0);
    chk("R1 b2", b2_out, '0);
    chk("R1 a sel0", a_out, '0);
    sel = 1; #1;
    chk("R1 a sel1", a_out, '0);
    rst = 0; sel = 0;
    step();

    for (int i = 0; i < 300; i++) begin
      w0 = wgen(i, 0); w1 = wgen(i, 1); w2 = wgen(i, 2);
      // R5 pair assembly
      a_in = w0; ld_a1_n = 0; ld_a2_n = 1; step();
      a_in = w1; ld_a1_n = 1; ld_a2_n = 0; step();
      chk("R5 first word on 1B", b1_out, w0);
      chk("R5 second word on 2B", b2_out, w1);
      // R4 hold with ld_a2_n high
      a_in = w2; ld_a2_n = 1; step();
      chk("R4 hold 1B", b1_out, w0);
      chk("R4 hold 2B", b2_out, w1);
      // R2 first stage held (ld_a1_n high), R3 second load
      a_in = w2; ld_a2_n = 0; step();
      chk("R2 stage1 held", b1_out, w0);
      chk("R3 2B load", b2_out, w2);
      // R6 both enables low together
      a_in = w1; ld_a1_n = 0; ld_a2_n = 0; step();
      chk("R6 1B gets old stage", b1_out, w0);
      chk("R6 2B gets new", b2_out, w1);
      a_in = w0; ld_a1_n = 1; ld_a2_n = 0; step();
      chk("R6 stage took new", b1_out, w1);
      chk("R3 2B load again", b2_out, w0);
      ld_a2_n = 1;
      // R7 / R8 B-to-A
      p = wgen(i, 3); q = wgen(i, 4);
      b1_in = p; b2_in = q; ld_b_n = 0; step();
      ld_b_n = 1; sel = 0; #1;
      chk("R8 sel0 gives 1B", a_out, p);
      sel = 1; #1;
      chk("R8 sel1 gives 2B", a_out, q);
      b1_in = ~p; b2_in = ~q; step();
      chk("R7 hold 2B capture", a_out, q);
      sel = 0; #1;
      chk("R7 hold 1B capture", a_out, p);
      step();
    end

    // R9 output enable sweep
    for (int m = 0; m < 8; m++) begin
      oe_a_n = m[0]; oe_b1_n = m[1]; oe_b2_n = m[2]; step();
      chk("R9 a_drv", W'(a_drv), W'(!m[0]));
      chk("R9 b1_drv", W'(b1_drv), W'(!m[1]));
      chk("R9 b2_drv", W'(b2_drv), W'(!m[2]));
      chk("R9 contents 1B", b1_out, w1);
      chk("R9 contents 2B", b2_out, w0);
      chk("R9 contents A", a_out, p);
    end

    // R10 reset beats loads
    a_in = 12'hABC; b1_in = 12'h123; b2_in = 12'h456;
    ld_a1_n = 0; ld_a2_n = 0; ld_b_n = 0; rst = 1; step();
    chk("R10 1B", b1_out, '0);
    chk("R10 2B", b2_out, '0);
    chk("R10 A", a_out, '0);
    rst = 0; ld_a1_n = 1; step();
    chk("R10 stage cleared", b1_out, '0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule